// File: doc/BRIEF.md
# Vertical Sync Qualifier and Field Detector

This block watches a digital composite sync level, `sync_in` (1 = sync tip), together with a one-cycle line reference pulse, `line_ref`, that marks the start of every video line. It runs on a sample clock locked to the line rate, with `SAMPLES_PER_LINE` (768) clocks per line. It measures each candidate sync pulse. Only a pulse that lasts at least two lines and starts close to a whole-line or half-line point counts as vertical sync. The half-line point of the start tells the two interlaced fields apart. Short low notches inside the pulse are bridged, so equalizing serrations do not split it. The decision does not depend on how many lines a field has, so 525-line and 625-line signals both lock.

On each qualified pulse the block emits a one-cycle `vsync_pulse` and updates `field_id`. It also reloads a line counter, `line_num`, so that a caption data slicer downstream can use `line21_win` to pick out the line that carries caption data. A lock monitor raises `lock_lost` when no vertical sync arrives for too many lines. It drops the flag again after consecutive good fields.

The pulse state machine has five states:
- ST_IDLE: waiting for sync. Sync high at an aligned phase goes to ST_HIGH (start). Sync high at any other phase goes to ST_REJECT (misaligned).
- ST_HIGH: inside the pulse. Sync low goes to ST_GAP (notch). Sync high once the pulse is long enough goes to ST_HOLD (qualify).
- ST_GAP: inside a notch. Sync high goes back to ST_HIGH (bridge), or to ST_HOLD (qualify) if the pulse is already long enough. A full-length low run goes to ST_IDLE (too short).
- ST_HOLD and ST_REJECT: both wait for a full-length low run and then return to ST_IDLE (release).

Top module: `vsync_field_detector`

## Requirements
- R1: Let t0 be the sampling edge at which a candidate pulse starts. A one-cycle `vsync_pulse` follows the first edge at or after t0+`VSYNC_MIN`-1 (`VSYNC_MIN` = 1536) at which `sync_in` is 1 while the pulse is still open. The pulse appears in the cycle after that edge.
- R2: A candidate that ends before `VSYNC_MIN`-1 cycles have elapsed since its start produces no `vsync_pulse`.
- R3: The phase of the start edge selects the field. A phase within `ALIGN_WIN`-1 counts of a line start (0..`ALIGN_WIN`-1 or `SAMPLES_PER_LINE`-`ALIGN_WIN`+1..`SAMPLES_PER_LINE`-1) gives field 1, `field_id`=0. A phase within `ALIGN_WIN`-1 counts of `SAMPLES_PER_LINE`/2 gives field 2, `field_id`=1. Any other phase is rejected and produces no `vsync_pulse`.
- R4: `field_id` changes only in the cycle that `vsync_pulse` is high.
- R5: Inside a candidate, a low run shorter than `SERR_MAX` (96) cycles is bridged. A low run of `SERR_MAX` cycles ends the candidate.
- R6: The phase is 0 at an edge where `line_ref` is 1. It rises by one on each later edge and saturates at 2·`SAMPLES_PER_LINE`-1.
- R7: `line_num` is loaded with `QUAL_LINE` (6) together with `vsync_pulse`. Otherwise it rises by one after each `line_ref` edge and saturates at 2^`LINE_W`-1 (1023).
- R8: `line21_win` is 1 exactly while `line_num` equals `TARGET_LINE` (21).
- R9: `lock_lost` is set once `LOSS_LINES` (700) `line_ref` edges pass with no qualification. It clears with the `RELOCK_FIELDS`-th (2nd) qualification after that.
- R10: After a qualification, no new candidate starts until `sync_in` has been low for `SERR_MAX` consecutive cycles, so one long pulse gives exactly one `vsync_pulse`.
- R11: After reset, `vsync_pulse`=0, `field_id`=0, `line_num`=0, `line21_win`=0 and `lock_lost`=1.
- R12: Fields of 525-line and of 625-line length both keep lock with alternating `field_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ref | input | 1 | One-cycle pulse at each line start |
| sync_in | input | 1 | Composite sync level, 1 = sync tip |
| vsync_pulse | output | 1 | One-cycle strobe on a qualified vertical pulse |
| field_id | output | 1 | 0 = field 1, 1 = field 2 |
| line_num | output | LINE_W | Line counter, reloaded at qualification |
| line21_win | output | 1 | High during the target caption line |
| lock_lost | output | 1 | No vertical sync seen within the loss window |

## Verification
The hardest corner to reach is the exact serration boundary. Here a notch of `SERR_MAX`-1 cycles must be bridged, while a notch of `SERR_MAX` cycles must end the pulse. The later high run must then fall at a rejected phase instead of starting a new pulse. Just as hard is the relock path, which needs hundreds of lines without any vertical interval and then two full fields. The bench makes both affordable by building the block with scaled parameters: 64 samples per line, 8-cycle serration limit, 128-cycle minimum, and 40-line loss window. It drives raw pulses at chosen phase offsets next to whole interlaced fields, and a behavioural model is compared every clock.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_GAP,
        ST_HOLD,
        ST_REJECT
    } vsq_state_e;

    typedef enum logic [1:0] {
        ALIGN_NONE,
        ALIGN_F1,
        ALIGN_F2
    } vsq_align_e;
endpackage

// File: rtl/vsq_phase_tracker.sv
module vsq_phase_tracker
    import vsq_pkg::*;
#(
    parameter int SAMPLES_PER_LINE = 768,
    parameter int ALIGN_WIN        = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_ref,
    output vsq_align_e align
);
    localparam int PH_MAX_I = 2 * SAMPLES_PER_LINE - 1;
    localparam int PH_W     = $clog2(2 * SAMPLES_PER_LINE);
    localparam int HALF     = SAMPLES_PER_LINE / 2;

    localparam logic [PH_W-1:0] PH_MAX  = PH_W'(PH_MAX_I);
    localparam logic [PH_W-1:0] F1_LO   = PH_W'(ALIGN_WIN);
    localparam logic [PH_W-1:0] F1_HI   = PH_W'(SAMPLES_PER_LINE - ALIGN_WIN + 1);
    localparam logic [PH_W-1:0] LINE_E  = PH_W'(SAMPLES_PER_LINE);
    localparam logic [PH_W-1:0] F2_LO   = PH_W'(HALF - ALIGN_WIN + 1);
    localparam logic [PH_W-1:0] F2_HI   = PH_W'(HALF + ALIGN_WIN);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] cur_ph;

    // phase seen at this edge: zero on the reference pulse itself
    assign cur_ph = line_ref ? '0 : ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (cur_ph == PH_MAX) begin
            ph_q <= PH_MAX;
        end else begin
            ph_q <= cur_ph + 1'b1;
        end
    end

    always_comb begin
        if (cur_ph < F1_LO || (cur_ph >= F1_HI && cur_ph < LINE_E)) begin
            align = ALIGN_F1;
        end else if (cur_ph >= F2_LO && cur_ph < F2_HI) begin
            align = ALIGN_F2;
        end else begin
            align = ALIGN_NONE;
        end
    end
endmodule

// File: rtl/vsq_pulse_fsm.sv
module vsq_pulse_fsm
    import vsq_pkg::*;
#(
    parameter int VSYNC_MIN = 1536,
    parameter int SERR_MAX  = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  vsq_align_e align,
    output logic       qual_now,
    output logic       vsync_pulse,
    output logic       field_id
);
    localparam int EL_W  = $clog2(VSYNC_MIN + 1);
    localparam int GAP_W = $clog2(SERR_MAX + 1);

    localparam logic [EL_W-1:0]  EL_MAX   = EL_W'(VSYNC_MIN);
    localparam logic [EL_W-1:0]  EL_LAST  = EL_W'(VSYNC_MIN - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SERR_MAX - 1);

    vsq_state_e       st_q, st_n;
    logic [EL_W-1:0]  el_q, el_n, el_inc;
    logic [GAP_W-1:0] gap_q, gap_n;
    logic             cf_q, cf_n;

    assign el_inc = (el_q == EL_MAX) ? el_q : el_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            el_q  <= '0;
            gap_q <= '0;
            cf_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            el_q  <= el_n;
            gap_q <= gap_n;
            cf_q  <= cf_n;
        end
    end

    // next state and qualification decision
    always_comb begin
        st_n     = st_q;
        el_n     = el_q;
        gap_n    = gap_q;
        cf_n     = cf_q;
        qual_now = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (sync_in) begin
                    gap_n = '0;
                    if (align != ALIGN_NONE) begin
                        st_n = ST_HIGH;
                        el_n = EL_W'(1);
                        cf_n = (align == ALIGN_F2);
                    end else begin
                        st_n = ST_REJECT;
                    end
                end
            end
            ST_HIGH, ST_GAP: begin
                if (sync_in) begin
                    if (el_q >= EL_LAST) begin
                        qual_now = 1'b1;
                        st_n     = ST_HOLD;
                        gap_n    = '0;
                    end else begin
                        st_n = ST_HIGH;
                        el_n = el_inc;
                    end
                end else if (st_q == ST_HIGH) begin
                    st_n  = ST_GAP;
                    gap_n = GAP_W'(1);
                    el_n  = el_inc;
                end else if (gap_q == GAP_LAST) begin
                    st_n = ST_IDLE;
                end else begin
                    gap_n = gap_q + 1'b1;
                    el_n  = el_inc;
                end
            end
            ST_HOLD, ST_REJECT: begin
                if (sync_in) begin
                    gap_n = '0;
                end else if (gap_q == GAP_LAST) begin
                    st_n = ST_IDLE;
                end else begin
                    gap_n = gap_q + 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync_pulse <= 1'b0;
            field_id    <= 1'b0;
        end else begin
            vsync_pulse <= qual_now;
            if (qual_now) begin
                field_id <= cf_q;
            end
        end
    end
endmodule

// File: rtl/vsq_line_timer.sv
module vsq_line_timer #(
    parameter int LINE_W        = 10,
    parameter int QUAL_LINE     = 6,
    parameter int TARGET_LINE   = 21,
    parameter int LOSS_LINES    = 700,
    parameter int RELOCK_FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_ref,
    input  logic              qual_now,
    output logic [LINE_W-1:0] line_num,
    output logic              line21_win,
    output logic              lock_lost
);
    localparam int SINCE_W = $clog2(LOSS_LINES + 1);
    localparam int RUN_W   = $clog2(RELOCK_FIELDS + 1);

    localparam logic [LINE_W-1:0]  LINE_MAX  = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0]  LOAD_VAL  = LINE_W'(QUAL_LINE);
    localparam logic [LINE_W-1:0]  TGT_VAL   = LINE_W'(TARGET_LINE);
    localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(LOSS_LINES);
    localparam logic [SINCE_W-1:0] SINCE_TOP = SINCE_W'(LOSS_LINES - 1);
    localparam logic [RUN_W-1:0]   RUN_TOP   = RUN_W'(RELOCK_FIELDS - 1);

    logic [LINE_W-1:0]  line_n;
    logic [SINCE_W-1:0] since_q;
    logic [RUN_W-1:0]   run_q;

    always_comb begin
        if (qual_now) begin
            line_n = LOAD_VAL;
        end else if (line_ref && line_num != LINE_MAX) begin
            line_n = line_num + 1'b1;
        end else begin
            line_n = line_num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_num   <= '0;
            line21_win <= 1'b0;
        end else begin
            line_num   <= line_n;
            line21_win <= (line_n == TGT_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q   <= '0;
            run_q     <= '0;
            lock_lost <= 1'b1;
        end else if (qual_now) begin
            since_q <= '0;
            if (lock_lost) begin
                if (run_q == RUN_TOP) begin
                    lock_lost <= 1'b0;
                    run_q     <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end else if (line_ref) begin
            if (since_q != SINCE_MAX) begin
                since_q <= since_q + 1'b1;
            end
            if (since_q == SINCE_TOP) begin
                lock_lost <= 1'b1;
                run_q     <= '0;
            end
        end
    end
endmodule

// File: rtl/vsync_field_detector.sv
module vsync_field_detector
    import vsq_pkg::*;
#(
    parameter int SAMPLES_PER_LINE = 768,
    parameter int ALIGN_WIN        = 48,
    parameter int VSYNC_MIN        = 1536,
    parameter int SERR_MAX         = 96,
    parameter int LINE_W           = 10,
    parameter int QUAL_LINE        = 6,
    parameter int TARGET_LINE      = 21,
    parameter int LOSS_LINES       = 700,
    parameter int RELOCK_FIELDS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_ref,
    input  logic              sync_in,
    output logic              vsync_pulse,
    output logic              field_id,
    output logic [LINE_W-1:0] line_num,
    output logic              line21_win,
    output logic              lock_lost
);
    vsq_align_e align;
    logic       qual_now;

    vsq_phase_tracker #(
        .SAMPLES_PER_LINE(SAMPLES_PER_LINE),
        .ALIGN_WIN       (ALIGN_WIN)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_ref(line_ref),
        .align   (align)
    );

    vsq_pulse_fsm #(
        .VSYNC_MIN(VSYNC_MIN),
        .SERR_MAX (SERR_MAX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .align      (align),
        .qual_now   (qual_now),
        .vsync_pulse(vsync_pulse),
        .field_id   (field_id)
    );

    vsq_line_timer #(
        .LINE_W       (LINE_W),
        .QUAL_LINE    (QUAL_LINE),
        .TARGET_LINE  (TARGET_LINE),
        .LOSS_LINES   (LOSS_LINES),
        .RELOCK_FIELDS(RELOCK_FIELDS)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_ref  (line_ref),
        .qual_now  (qual_now),
        .line_num  (line_num),
        .line21_win(line21_win),
        .lock_lost (lock_lost)
    );
endmodule

// File: rtl/vsq_checker.sv
module vsq_checker #(
    parameter int LINE_W    = 10,
    parameter int QUAL_LINE = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_ref,
    input logic              vsync_pulse,
    input logic              field_id,
    input logic [LINE_W-1:0] line_num,
    input logic              lock_lost
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    vsync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> !vsync_pulse);

    // R4
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !vsync_pulse) |-> $stable(field_id));

    // R7
    line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |-> (line_num == LINE_W'(QUAL_LINE)));

    // R7
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !vsync_pulse && $past(line_ref) && $past(line_num) != LINE_MAX)
        |-> (line_num == $past(line_num) + 1'b1));

    // R9
    lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(lock_lost)) |-> !vsync_pulse);

    // R9
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(lock_lost)) |-> vsync_pulse);
endmodule

bind vsync_field_detector vsq_checker #(
    .LINE_W   (LINE_W),
    .QUAL_LINE(QUAL_LINE)
) u_vsq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_ref   (line_ref),
    .vsync_pulse(vsync_pulse),
    .field_id   (field_id),
    .line_num   (line_num),
    .lock_lost  (lock_lost)
);

// File: tb/tb_vsync_field_detector.sv
module tb_vsync_field_detector;
    localparam int CLK_PERIOD = 10;
    localparam int LINE   = 64;
    localparam int HALF   = LINE / 2;
    localparam int WIN    = 4;
    localparam int VMIN   = 128;
    localparam int SERR   = 8;
    localparam int QLINE  = 6;
    localparam int TLINE  = 21;
    localparam int LOSS   = 40;
    localparam int RELOCK = 2;
    localparam int LW     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_ref = 1'b0;
    logic sync_in = 1'b0;
    logic vsync_pulse, field_id, line21_win, lock_lost;
    logic [LW-1:0] line_num;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit live = 0;
    int bph = 0;
    int vs_cnt = 0;
    int last_field = 0;
    int l21_cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsync_field_detector #(
        .SAMPLES_PER_LINE(LINE), .ALIGN_WIN(WIN), .VSYNC_MIN(VMIN),
        .SERR_MAX(SERR), .LINE_W(LW), .QUAL_LINE(QLINE),
        .TARGET_LINE(TLINE), .LOSS_LINES(LOSS), .RELOCK_FIELDS(RELOCK)
    ) dut (
        .clk(clk), .rst_n(rst_n), .line_ref(line_ref), .sync_in(sync_in),
        .vsync_pulse(vsync_pulse), .field_id(field_id), .line_num(line_num),
        .line21_win(line21_win), .lock_lost(lock_lost)
    );

    // behavioural reference model
    int m_ph, m_mode, m_t, m_low, m_cf, m_since, m_run, cur;
    bit q;
    int e_vs, e_field, e_line, e_l21, e_lost;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_t = 0; m_low = 0; m_cf = 0;
            m_since = 0; m_run = 0;
            e_vs = 0; e_field = 0; e_line = 0; e_l21 = 0; e_lost = 1;
        end else begin
            q = 0;
            cur = line_ref ? 0 : m_ph;
            m_ph = (cur + 1 > 2*LINE - 1) ? 2*LINE - 1 : cur + 1;
            if (m_mode == 0) begin
                if (sync_in) begin
                    m_low = 0;
                    if (cur < LINE && (cur < WIN || cur > LINE - WIN)) begin
                        m_mode = 1; m_t = 0; m_cf = 0;
                    end else if (cur > HALF - WIN && cur < HALF + WIN) begin
                        m_mode = 1; m_t = 0; m_cf = 1;
                    end else begin
                        m_mode = 2;
                    end
                end
            end else if (m_mode == 1) begin
                m_t++;
                if (sync_in) begin
                    m_low = 0;
                    if (m_t >= VMIN - 1) begin q = 1; m_mode = 2; end
                end else begin
                    m_low++;
                    if (m_low == SERR) m_mode = 0;
                end
            end else begin
                if (sync_in) m_low = 0;
                else begin
                    m_low++;
                    if (m_low == SERR) m_mode = 0;
                end
            end
            e_vs = q;
            if (q) e_field = m_cf;
            if (q) begin
                e_line = QLINE; m_since = 0;
                if (e_lost == 1) begin
                    m_run++;
                    if (m_run == RELOCK) begin e_lost = 0; m_run = 0; end
                end
            end else if (line_ref) begin
                if (e_line < (1 << LW) - 1) e_line++;
                if (m_since == LOSS - 1) begin e_lost = 1; m_run = 0; end
                if (m_since < LOSS) m_since++;
            end
            e_l21 = (e_line == TLINE);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (live) begin
            chk(vsync_pulse == e_vs[0], "R1 vsync_pulse", vsync_pulse, e_vs);
            chk(field_id == e_field[0], "R4 field_id", field_id, e_field);
            chk(int'(line_num) == e_line, "R7 line_num", line_num, e_line);
            chk(line21_win == e_l21[0], "R8 line21_win", line21_win, e_l21);
            chk(lock_lost == e_lost[0], "R9 lock_lost", lock_lost, e_lost);
            if (vsync_pulse) begin vs_cnt++; last_field = field_id; end
            if (line21_win) l21_cycles++;
        end
    end

    task automatic step(input bit s);
        @(negedge clk);
        line_ref = (bph == 0);
        sync_in = s;
        bph = (bph + 1) % LINE;
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic align_line();
        while (bph != 0) step(1'b0);
    endtask

    // kind 0: normal half line, 1: equalizing, 2: serrated vertical
    task automatic half(input int kind);
        for (int i = 0; i < HALF; i++) begin
            if (kind == 0)      step(bph < 5);
            else if (kind == 1) step(i < 2);
            else                step(i < HALF - 4);
        end
    endtask

    task automatic field(input int normal_halves);
        for (int i = 0; i < 6; i++) half(1);
        for (int i = 0; i < 6; i++) half(2);
        for (int i = 0; i < 6; i++) half(1);
        for (int i = 0; i < normal_halves; i++) half(0);
    endtask

    int v0, fl0;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(vsync_pulse == 1'b0, "R11 vsync_pulse", vsync_pulse, 0);
        chk(field_id == 1'b0, "R11 field_id", field_id, 0);
        chk(line_num == '0, "R11 line_num", line_num, 0);
        chk(line21_win == 1'b0, "R11 line21_win", line21_win, 0);
        chk(lock_lost == 1'b1, "R11 lock_lost", lock_lost, 1);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        lows(2 * LINE);
        align_line();

        // 525-style fields: 26.5 lines each
        v0 = vs_cnt;
        for (int f = 0; f < 4; f++) begin
            field(35);
            if (f == 0) fl0 = last_field;
        end
        chk(vs_cnt - v0 == 4, "R1 vsync count 525", vs_cnt - v0, 4);
        chk(fl0 == 0, "R3 first field is field 1", fl0, 0);
        chk(last_field == 1, "R3 last field is field 2", last_field, 1);
        chk(lock_lost == 1'b0, "R9 lock after two fields", lock_lost, 0);
        chk(l21_cycles > 0, "R8 target line seen", l21_cycles, 1);

        // 625-style fields: 31.5 lines each
        v0 = vs_cnt;
        for (int f = 0; f < 4; f++) field(45);
        chk(vs_cnt - v0 == 4, "R12 vsync count 625", vs_cnt - v0, 4);
        chk(lock_lost == 1'b0, "R12 lock kept 625", lock_lost, 0);

        // misaligned start
        lows(2 * SERR); align_line(); lows(10);
        v0 = vs_cnt; highs(200); lows(2 * SERR);
        chk(vs_cnt == v0, "R3 misaligned rejected", vs_cnt - v0, 0);

        // too short
        align_line(); v0 = vs_cnt; highs(100); lows(2 * SERR);
        chk(vs_cnt == v0, "R2 short pulse rejected", vs_cnt - v0, 0);

        // notch of SERR ends the candidate
        align_line(); v0 = vs_cnt; highs(80); lows(SERR); highs(100); lows(2 * SERR);
        chk(vs_cnt == v0, "R5 full notch ends pulse", vs_cnt - v0, 0);

        // notch of SERR-1 is bridged
        align_line(); v0 = vs_cnt; highs(80); lows(SERR - 1); highs(100); lows(2 * SERR);
        chk(vs_cnt - v0 == 1, "R5 short notch bridged", vs_cnt - v0, 1);
        chk(last_field == 0, "R3 line start gives field 1", last_field, 0);

        // half-line start, edge of window; long pulse gives one strobe
        align_line(); lows(HALF + WIN - 1);
        v0 = vs_cnt; highs(300); lows(2 * SERR);
        chk(vs_cnt - v0 == 1, "R10 one strobe per long pulse", vs_cnt - v0, 1);
        chk(last_field == 1, "R6 phase from line_ref gives field 2", last_field, 1);

        // just outside the half-line window
        align_line(); lows(HALF + WIN);
        v0 = vs_cnt; highs(200); lows(2 * SERR);
        chk(vs_cnt == v0, "R3 outside window rejected", vs_cnt - v0, 0);

        // loss of lock and relock
        align_line();
        for (int i = 0; i < 2 * (LOSS + 5); i++) half(0);
        chk(lock_lost == 1'b1, "R9 loss after window", lock_lost, 1);
        field(35);
        chk(lock_lost == 1'b1, "R9 still lost after one field", lock_lost, 1);
        field(35);
        chk(lock_lost == 1'b0, "R9 relock after two fields", lock_lost, 0);

        // line counter saturation
        for (int i = 0; i < 2 * 1030; i++) half(0);
        chk(line_num == {LW{1'b1}}, "R7 line_num saturates", line_num, (1 << LW) - 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule